// File: doc/BRIEF.md
# In-Order Line Fetch Request Tracker

This block follows each instruction-line fetch from the moment it is accepted until its line is handed on, and it keeps lines in program order. An upstream fetcher pushes a request tagged with a PC and two tags: a stream tag and a prediction tag. From then on the entry sits in a pending region. It waits there for its address translation and then for its turn to be sent to the instruction cache. After that it sits in a transfer region until its memory data is back. Only the oldest pending entry may advance. A faulted entry, or one whose tags no longer match the live tags, advances with no memory access.

The cache request port may refuse a request. After a refusal the block waits in a retry state and sends nothing until the cache signals retry. Memory responses are never back-pressured, and they return in issue order. When the oldest transfer entry is complete it is popped. A popped entry whose tags are current becomes one output line. A popped entry whose tags are out of date releases its reserved downstream slot instead. Stale entries are therefore dropped lazily, only at a queue head, and never while the translator or memory still holds them.

Top module: `fetch_line_queue`

## Requirements
- R1: After reset the in-flight count is 0, `push_ready_o` is 1, and `line_valid_o`, `slot_free_o`, `mem_req_valid_o` and `retry_wait_o` are 0.
- R2: No more than `LIMIT` entries are in flight at once. At the limit `push_ready_o` is 0 and a push has no effect. The in-flight count changes by at most one per cycle.
- R3: Cache requests are raised only for the oldest pending entry. Requests and output lines follow push order, and a younger entry is never sent ahead of an older one.
- R4: A translated pending-head entry with no fault and current tags drives `mem_req_valid_o` with its PC. When `mem_req_ready_i` is also high, the entry moves on and the next entry becomes the head.
- R5: A pending-head entry whose translation faulted, and whose tags are current, makes no cache request. It is delivered as a line with the fault flag set and data 0.
- R6: A refused request (`mem_req_valid_o` high, `mem_req_ready_i` low) sets `retry_wait_o`. While it is set and `mem_retry_i` is low, `mem_req_valid_o` stays 0 whatever `mem_req_ready_i` does.
- R7: In the retry state, `mem_retry_i` re-sends the pending head in the same cycle. `retry_wait_o` clears unless that send is refused again.
- R8: A memory response is always taken. It completes the oldest entry awaiting memory, and its data appears on the output line.
- R9: A translated entry whose stream tag or prediction tag differs from the live value is not sent to the cache. It produces a one-cycle `slot_free_o` pulse and no line.
- R10: An entry that goes stale after it was sent stays in flight until its response arrives. It is then dropped with a `slot_free_o` pulse and no line.
- R11: Each output line is a one-cycle `line_valid_o` pulse carrying the entry's data, fault flag, stream tag, prediction tag and PC. `line_valid_o` and `slot_free_o` are never high together.
- R12: `drained_o` is 1 exactly when `halted_i` is 1, the in-flight count is 0 and no line is being output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | New fetch request |
| push_pc_i | input | PC_W | PC of the new request |
| push_stream_i | input | TAG_W | Stream tag of the new request |
| push_pred_i | input | TAG_W | Prediction tag of the new request |
| push_ready_o | output | 1 | Space for another in-flight entry |
| live_stream_i | input | TAG_W | Current stream tag |
| live_pred_i | input | TAG_W | Current prediction tag |
| halted_i | input | 1 | Fetcher is halted |
| xlat_valid_i | input | 1 | Translation result for the oldest entry in translation |
| xlat_fault_i | input | 1 | That translation faulted |
| mem_req_valid_o | output | 1 | Cache request |
| mem_req_pc_o | output | PC_W | Cache request PC |
| mem_req_ready_i | input | 1 | Cache accepts the request |
| mem_retry_i | input | 1 | Cache can take a refused request again |
| mem_resp_valid_i | input | 1 | Memory response |
| mem_resp_data_i | input | DATA_W | Response data |
| line_valid_o | output | 1 | Output line valid |
| line_data_o | output | DATA_W | Line data |
| line_fault_o | output | 1 | Line fault flag |
| line_stream_o | output | TAG_W | Line stream tag |
| line_pred_o | output | TAG_W | Line prediction tag |
| line_pc_o | output | PC_W | Line PC |
| slot_free_o | output | 1 | Reserved downstream slot released |
| retry_wait_o | output | 1 | Waiting for cache retry |
| in_flight_o | output | $clog2(LIMIT+1) | Entries held in both regions |
| drained_o | output | 1 | Fetch path drained |

## Verification
The assertions check four rules on every cycle. A refused request always enters the wait state, and the block stays silent there until retry arrives. A line and a slot release never happen together. The in-flight count stays within its bound and moves by at most one per cycle. Other behaviour needs the bench's scenarios to show it: which entries are sent, dropped or delivered, and in what order. This covers head-of-queue blocking, lazy discard of entries that went stale before or after their cache request, and the field contents of each line. A sweep over fault and tag-mismatch combinations checks each outcome against values worked out in the bench.

// File: rtl/fetchq_pkg.sv
package fetchq_pkg;
  typedef enum logic [1:0] {
    ST_XLAT  = 2'd0,
    ST_TRANS = 2'd1,
    ST_ISSUE = 2'd2,
    ST_DONE  = 2'd3
  } fq_state_e;
endpackage

// File: rtl/fetchq_scan.sv
// Oldest entry with hit set, walking count_i slots of the ring from start_i.
module fetchq_scan #(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input  logic [DEPTH-1:0] hit_i,
  input  logic [IW-1:0]    start_i,
  input  logic [CW-1:0]    count_i,
  output logic             found_o,
  output logic [IW-1:0]    idx_o
);
  int j;
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    j       = 0;
    for (int k = 0; k < DEPTH; k++) begin
      j = int'(start_i) + k;
      if (j >= DEPTH) j = j - DEPTH;
      if (!found_o && (k < int'(count_i)) && hit_i[j[IW-1:0]]) begin
        found_o = 1'b1;
        idx_o   = j[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/fetchq_send_ctl.sv
// Pending-head advance and cache retry state.
module fetchq_send_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic head_ok_i,
  input  logic head_skip_i,
  input  logic ready_i,
  input  logic retry_i,
  output logic req_valid_o,
  output logic issue_o,
  output logic skip_o,
  output logic wait_o
);
  logic wait_q, wait_d, step;

  assign step        = !wait_q || retry_i;
  assign req_valid_o = step && head_ok_i && !head_skip_i;
  assign issue_o     = req_valid_o && ready_i;
  assign skip_o      = step && head_ok_i && head_skip_i;
  assign wait_o      = wait_q;

  always_comb begin
    wait_d = wait_q;
    if (req_valid_o && !ready_i) wait_d = 1'b1;
    else if (wait_q && retry_i)  wait_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b0;
    else         wait_q <= wait_d;
  end
endmodule

// File: rtl/fetchq_out.sv
// Registered line / slot-release output.
module fetchq_out #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              drop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fault_i,
  input  logic [TAG_W-1:0]  stream_i,
  input  logic [TAG_W-1:0]  pred_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              line_valid_o,
  output logic [DATA_W-1:0] line_data_o,
  output logic              line_fault_o,
  output logic [TAG_W-1:0]  line_stream_o,
  output logic [TAG_W-1:0]  line_pred_o,
  output logic [PC_W-1:0]   line_pc_o,
  output logic              slot_free_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_valid_o  <= 1'b0;
      slot_free_o   <= 1'b0;
      line_data_o   <= '0;
      line_fault_o  <= 1'b0;
      line_stream_o <= '0;
      line_pred_o   <= '0;
      line_pc_o     <= '0;
    end else begin
      line_valid_o <= pop_i && !drop_i;
      slot_free_o  <= pop_i && drop_i;
      if (pop_i && !drop_i) begin
        line_data_o   <= data_i;
        line_fault_o  <= fault_i;
        line_stream_o <= stream_i;
        line_pred_o   <= pred_i;
        line_pc_o     <= pc_i;
      end
    end
  end
endmodule

// File: rtl/fetch_line_queue.sv
module fetch_line_queue
  import fetchq_pkg::*;
#(
  parameter int LIMIT  = 4,
  parameter int PC_W   = 32,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_valid_i,
  input  logic [PC_W-1:0]              push_pc_i,
  input  logic [TAG_W-1:0]             push_stream_i,
  input  logic [TAG_W-1:0]             push_pred_i,
  output logic                         push_ready_o,
  input  logic [TAG_W-1:0]             live_stream_i,
  input  logic [TAG_W-1:0]             live_pred_i,
  input  logic                         halted_i,
  input  logic                         xlat_valid_i,
  input  logic                         xlat_fault_i,
  output logic                         mem_req_valid_o,
  output logic [PC_W-1:0]              mem_req_pc_o,
  input  logic                         mem_req_ready_i,
  input  logic                         mem_retry_i,
  input  logic                         mem_resp_valid_i,
  input  logic [DATA_W-1:0]            mem_resp_data_i,
  output logic                         line_valid_o,
  output logic [DATA_W-1:0]            line_data_o,
  output logic                         line_fault_o,
  output logic [TAG_W-1:0]             line_stream_o,
  output logic [TAG_W-1:0]             line_pred_o,
  output logic [PC_W-1:0]              line_pc_o,
  output logic                         slot_free_o,
  output logic                         retry_wait_o,
  output logic [$clog2(LIMIT+1)-1:0]   in_flight_o,
  output logic                         drained_o
);
  localparam int IW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam int CW = $clog2(LIMIT + 1);

  fq_state_e         st_q   [LIMIT];
  logic              flt_q  [LIMIT];
  logic [TAG_W-1:0]  strm_q [LIMIT];
  logic [TAG_W-1:0]  pred_q [LIMIT];
  logic [PC_W-1:0]   pc_q   [LIMIT];
  logic [DATA_W-1:0] data_q [LIMIT];

  // ring order: head_q .. split_q = transfer region, split_q .. tail_q = pending
  logic [IW-1:0] head_q, split_q, tail_q;
  logic [CW-1:0] pend_q, xfer_q, in_flight;

  logic [LIMIT-1:0] in_xlat, in_issue, discard;
  logic             xlat_hit, mem_hit;
  logic [IW-1:0]    xlat_idx, mem_idx;
  logic             head_ok, head_skip, issue, skip, move;
  logic             pop, pop_drop, push_acc;

  function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] p);
    return (p == IW'(LIMIT - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < LIMIT; g++) begin : g_ent
    assign in_xlat[g]  = (st_q[g] == ST_XLAT);
    assign in_issue[g] = (st_q[g] == ST_ISSUE);
    assign discard[g]  = !in_xlat[g] && !in_issue[g] &&
                         ((strm_q[g] != live_stream_i) || (pred_q[g] != live_pred_i));
  end

  fetchq_scan #(.DEPTH(LIMIT), .IW(IW), .CW(CW)) u_xlat_scan (
    .hit_i   (in_xlat),
    .start_i (split_q),
    .count_i (pend_q),
    .found_o (xlat_hit),
    .idx_o   (xlat_idx)
  );

  fetchq_scan #(.DEPTH(LIMIT), .IW(IW), .CW(CW)) u_mem_scan (
    .hit_i   (in_issue),
    .start_i (head_q),
    .count_i (xfer_q),
    .found_o (mem_hit),
    .idx_o   (mem_idx)
  );

  assign head_ok   = (pend_q != '0) && (st_q[split_q] == ST_TRANS);
  assign head_skip = flt_q[split_q] || discard[split_q];

  fetchq_send_ctl u_send (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_ok_i   (head_ok),
    .head_skip_i (head_skip),
    .ready_i     (mem_req_ready_i),
    .retry_i     (mem_retry_i),
    .req_valid_o (mem_req_valid_o),
    .issue_o     (issue),
    .skip_o      (skip),
    .wait_o      (retry_wait_o)
  );

  assign mem_req_pc_o = pc_q[split_q];
  assign move         = issue || skip;

  assign pop      = (xfer_q != '0) && (st_q[head_q] == ST_DONE);
  assign pop_drop = discard[head_q];

  fetchq_out #(.PC_W(PC_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_out (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pop_i         (pop),
    .drop_i        (pop_drop),
    .data_i        (data_q[head_q]),
    .fault_i       (flt_q[head_q]),
    .stream_i      (strm_q[head_q]),
    .pred_i        (pred_q[head_q]),
    .pc_i          (pc_q[head_q]),
    .line_valid_o  (line_valid_o),
    .line_data_o   (line_data_o),
    .line_fault_o  (line_fault_o),
    .line_stream_o (line_stream_o),
    .line_pred_o   (line_pred_o),
    .line_pc_o     (line_pc_o),
    .slot_free_o   (slot_free_o)
  );

  assign in_flight    = pend_q + xfer_q;
  assign in_flight_o  = in_flight;
  assign push_ready_o = (in_flight < CW'(LIMIT));
  assign push_acc     = push_valid_i && push_ready_o;
  assign drained_o    = halted_i && (in_flight == '0) && !line_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      split_q <= '0;
      tail_q  <= '0;
      pend_q  <= '0;
      xfer_q  <= '0;
    end else begin
      if (push_acc) tail_q  <= ring_next(tail_q);
      if (move)     split_q <= ring_next(split_q);
      if (pop)      head_q  <= ring_next(head_q);
      pend_q <= pend_q + CW'(push_acc) - CW'(move);
      xfer_q <= xfer_q + CW'(move) - CW'(pop);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LIMIT; i++) begin
        st_q[i]   <= ST_DONE;
        flt_q[i]  <= 1'b0;
        strm_q[i] <= '0;
        pred_q[i] <= '0;
        pc_q[i]   <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (push_acc) begin
        st_q[tail_q]   <= ST_XLAT;
        flt_q[tail_q]  <= 1'b0;
        strm_q[tail_q] <= push_stream_i;
        pred_q[tail_q] <= push_pred_i;
        pc_q[tail_q]   <= push_pc_i;
        data_q[tail_q] <= '0;
      end
      if (xlat_valid_i && xlat_hit) begin
        st_q[xlat_idx]  <= ST_TRANS;
        flt_q[xlat_idx] <= xlat_fault_i;
      end
      if (issue) st_q[split_q] <= ST_ISSUE;
      if (skip)  st_q[split_q] <= ST_DONE;
      if (mem_resp_valid_i && mem_hit) begin
        st_q[mem_idx]   <= ST_DONE;
        data_q[mem_idx] <= mem_resp_data_i;
      end
    end
  end
endmodule

// File: rtl/fetch_line_queue_chk.sv
module fetch_line_queue_chk #(
  parameter int LIMIT = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       mem_req_valid_i,
  input logic                       mem_req_ready_i,
  input logic                       mem_retry_i,
  input logic                       retry_wait_i,
  input logic                       line_valid_i,
  input logic                       slot_free_i,
  input logic [$clog2(LIMIT+1)-1:0] in_flight_i
);
  localparam int CW = $clog2(LIMIT + 1);

  a_r6_reject_enters_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_i && !mem_req_ready_i) |=> retry_wait_i);

  a_r6_quiet_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_wait_i && !mem_retry_i) |-> !mem_req_valid_i);

  a_r7_retry_clears_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_wait_i && mem_retry_i && (!mem_req_valid_i || mem_req_ready_i)) |=> !retry_wait_i);

  a_r11_single_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_valid_i && slot_free_i));

  a_r2_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, in_flight_i} <= (CW+1)'(LIMIT)));

  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (({1'b0, in_flight_i} <= {1'b0, $past(in_flight_i)} + 1'b1) &&
     ({1'b0, $past(in_flight_i)} <= {1'b0, in_flight_i} + 1'b1)));
endmodule

bind fetch_line_queue fetch_line_queue_chk #(.LIMIT(LIMIT)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mem_req_valid_i (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_retry_i     (mem_retry_i),
  .retry_wait_i    (retry_wait_o),
  .line_valid_i    (line_valid_o),
  .slot_free_i     (slot_free_o),
  .in_flight_i     (in_flight_o)
);

// File: tb/fetch_line_queue_test.sv
`timescale 1ns/1ps
module fetch_line_queue_test;
  localparam int LIMIT = 4;
  localparam int PC_W = 16, DATA_W = 16, TAG_W = 2;
  localparam int CW = $clog2(LIMIT + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic push_valid = 0; logic [PC_W-1:0] push_pc = 0;
  logic [TAG_W-1:0] push_s = 0, push_p = 0, live_s = 0, live_p = 0;
  logic halted = 1, xv = 0, xf = 0, mready = 1, mretry = 0, rv = 0;
  logic [DATA_W-1:0] rdata = 0;
  logic push_ready, mreq_v, line_v, line_f, slot_free, rwait, drained;
  logic [PC_W-1:0] mreq_pc, line_pc;
  logic [DATA_W-1:0] line_d;
  logic [TAG_W-1:0] line_s, line_p;
  logic [CW-1:0] in_flight;

  always #5 clk = ~clk;

  fetch_line_queue #(.LIMIT(LIMIT), .PC_W(PC_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .push_valid_i(push_valid), .push_pc_i(push_pc), .push_stream_i(push_s), .push_pred_i(push_p),
    .push_ready_o(push_ready), .live_stream_i(live_s), .live_pred_i(live_p), .halted_i(halted),
    .xlat_valid_i(xv), .xlat_fault_i(xf),
    .mem_req_valid_o(mreq_v), .mem_req_pc_o(mreq_pc), .mem_req_ready_i(mready), .mem_retry_i(mretry),
    .mem_resp_valid_i(rv), .mem_resp_data_i(rdata),
    .line_valid_o(line_v), .line_data_o(line_d), .line_fault_o(line_f),
    .line_stream_o(line_s), .line_pred_o(line_p), .line_pc_o(line_pc),
    .slot_free_o(slot_free), .retry_wait_o(rwait), .in_flight_o(in_flight), .drained_o(drained)
  );

  int n_tests = 0, n_fail = 0, done = 0;
  logic [PC_W-1:0] req_pc [64];
  logic [PC_W-1:0] ln_pc [64];
  logic [DATA_W-1:0] ln_d [64];
  logic ln_f [64];
  logic [TAG_W-1:0] ln_s [64], ln_p [64];
  int nreq = 0, nline = 0, nfree = 0, ridx = 0;

  // monitor: 1 ns before each rising edge
  always begin
    @(negedge clk); #4;
    if (rst_ni) begin
      if (mreq_v && mready) begin req_pc[nreq % 64] = mreq_pc; nreq++; end
      if (line_v) begin
        ln_pc[nline % 64] = line_pc; ln_d[nline % 64] = line_d; ln_f[nline % 64] = line_f;
        ln_s[nline % 64] = line_s; ln_p[nline % 64] = line_p; nline++;
      end
      if (slot_free) nfree++;
    end
  end

  function automatic logic [DATA_W-1:0] mdat(input logic [PC_W-1:0] pc);
    return pc * 16'd7 + 16'h0013;
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(); endtask
  task automatic push(input logic [PC_W-1:0] pc, input logic [TAG_W-1:0] s, input logic [TAG_W-1:0] p);
    push_valid = 1; push_pc = pc; push_s = s; push_p = p; step(); push_valid = 0;
  endtask
  task automatic xl(input logic f); xv = 1; xf = f; step(); xv = 0; xf = 0; endtask
  task automatic resp();
    rv = 1; rdata = mdat(req_pc[ridx % 64]); ridx++; step(); rv = 0;
  endtask
  task automatic chk_line(input string r, input int i, input logic [PC_W-1:0] pc,
                          input logic [DATA_W-1:0] d, input logic f);
    chk({r, " pc"}, 32'(ln_pc[i]), 32'(pc));
    chk({r, " data"}, 32'(ln_d[i]), 32'(d));
    chk({r, " fault"}, 32'(ln_f[i]), 32'(f));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int b, q, f0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 in_flight", 32'(in_flight), 0);
    chk("R1 push_ready", 32'(push_ready), 1);
    chk("R1 outputs", 32'({line_v, slot_free, mreq_v, rwait}), 0);
    chk("R12 drained halted idle", 32'(drained), 1);
    halted = 0;
    step();
    chk("R12 not halted", 32'(drained), 0);

    // R4 R8 R11 R3: three clean lines in order
    b = nline; q = nreq;
    push(16'h0100, 2'd0, 2'd0); push(16'h0110, 2'd0, 2'd0); push(16'h0120, 2'd0, 2'd0);
    xl(0); xl(0); xl(0); idle(3);
    chk("R4 requests sent", 32'(nreq - q), 3);
    for (int i = 0; i < 3; i++) chk("R3 request order", 32'(req_pc[q + i]), 32'(16'h0100 + i * 16));
    resp(); resp(); resp(); idle(5);
    chk("R8 lines out", 32'(nline - b), 3);
    for (int i = 0; i < 3; i++)
      chk_line("R11 R3 line", b + i, 16'h0100 + 16'(i * 16), mdat(16'h0100 + 16'(i * 16)), 0);
    chk("R2 in_flight drained", 32'(in_flight), 0);

    // sweep: fault x stream mismatch x prediction mismatch (R5 R9)
    for (int c = 0; c < 8; c++) begin
      logic flt, stl;
      logic [PC_W-1:0] pc;
      int l0, r0, fr0;
      flt = c[0]; stl = c[1] | c[2]; pc = 16'h0200 + 16'(c * 16);
      l0 = nline; r0 = nreq; fr0 = nfree;
      push(pc, {1'b0, c[1]}, {1'b0, c[2]});
      xl(flt); idle(3);
      if (nreq != r0) resp();
      idle(5);
      chk("R9 R5 request made", 32'(nreq - r0), 32'((!stl && !flt) ? 1 : 0));
      chk("R9 slot freed", 32'(nfree - fr0), 32'(stl ? 1 : 0));
      chk("R5 R9 line made", 32'(nline - l0), 32'(stl ? 0 : 1));
      if (!stl) chk_line("R5 sweep line", l0, pc, flt ? '0 : mdat(pc), flt);
    end

    // R6 R7 refusal, wait, retry; younger entry held behind head (R3)
    b = nline; q = nreq; mready = 0;
    push(16'h0300, 2'd0, 2'd0); push(16'h0310, 2'd0, 2'd0);
    xl(0); xl(0); idle(2);
    chk("R6 wait set", 32'(rwait), 1);
    chk("R6 quiet", 32'(mreq_v), 0);
    mready = 1; idle(2);
    chk("R6 quiet with ready", 32'(mreq_v), 0);
    chk("R6 nothing accepted", 32'(nreq - q), 0);
    mretry = 1; #1;
    chk("R7 resend same cycle", 32'(mreq_v), 1);
    chk("R7 resend head pc", 32'(mreq_pc), 32'(16'h0300));
    step(); mretry = 0;
    chk("R7 wait cleared", 32'(rwait), 0);
    idle(2);
    chk("R3 both sent", 32'(nreq - q), 2);
    chk("R3 retry order", 32'(req_pc[q + 1]), 32'(16'h0310));
    resp(); resp(); idle(5);
    chk("R8 retry lines", 32'(nline - b), 2);
    chk_line("R11 retry line0", b, 16'h0300, mdat(16'h0300), 0);
    chk_line("R11 retry line1", b + 1, 16'h0310, mdat(16'h0310), 0);

    // R10 stale after send: held until response, then dropped
    b = nline; f0 = nfree;
    push(16'h0400, 2'd1, 2'd2); 
    live_s = 2'd1; live_p = 2'd2;
    xl(0); idle(2);
    live_p = 2'd3; idle(4);
    chk("R10 held in flight", 32'(in_flight), 1);
    chk("R10 not freed early", 32'(nfree - f0), 0);
    resp(); idle(5);
    chk("R10 freed after response", 32'(nfree - f0), 1);
    chk("R10 no line", 32'(nline - b), 0);
    chk("R10 in_flight zero", 32'(in_flight), 0);
    live_s = 0; live_p = 0;

    // R2 capacity sweep over every fill level
    for (int n = 1; n <= LIMIT; n++) begin
      b = nline;
      for (int i = 0; i < n; i++) push(16'h0500 + 16'(i * 16), 2'd0, 2'd0);
      chk("R2 fill count", 32'(in_flight), 32'(n));
      chk("R2 push_ready", 32'(push_ready), 32'(n < LIMIT));
      if (n == LIMIT) begin
        push(16'h0FF0, 2'd0, 2'd0);
        chk("R2 push ignored at limit", 32'(in_flight), 32'(LIMIT));
      end
      for (int i = 0; i < n; i++) xl(0);
      idle(2);
      for (int i = 0; i < n; i++) resp();
      idle(5);
      chk("R2 fill lines", 32'(nline - b), 32'(n));
      chk("R3 fill last pc", 32'(ln_pc[b + n - 1]), 32'(16'h0500 + (n - 1) * 16));
      chk("R2 refill empty", 32'(in_flight), 0);
    end

    // R12 drained
    halted = 1; step();
    chk("R12 drained", 32'(drained), 1);
    push(16'h0600, 2'd0, 2'd0);
    chk("R12 busy not drained", 32'(drained), 0);
    xl(1); idle(5);
    chk("R12 drained again", 32'(drained), 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule